// File: doc/BRIEF.md
# Cache Request-Path Stall Controller

This block decides when the processor-facing request path of a cache has to stop taking new requests. It follows the occupancy of two buffer queues, the miss-tracking queue and the write buffer, from their allocate and retire-to-service strobes. It also accepts a separate stall reason, raised and dropped from outside, that means a miss entry has run out of target slots. Each reason owns one bit of a small stall mask. The block drives a single `stall_o` line whenever any bit is set.

Alongside the stall decision, the block keeps per-reason statistics. A stall episode opens only when the mask goes from empty to non-empty. The reason that opens it gets its episode counter bumped, and the current cycle number is latched. The episode closes when the mask drains to empty. The elapsed cycles are then added to the cycle total of the reason whose clear emptied the mask. The block also hands out a global allocation sequence number to every accepted allocation. It produces the block-aligned line address used for miss allocations.

All stall and statistic pins are plain control and status signals. The block has no data stream, so no valid/ready handshake applies at its edge. Allocation strobes are level pulses that the block either accepts or ignores in the same cycle.

Top module: `cache_stall_ctrl`

## Requirements
- R1: After reset the stall mask is 000, `stall_o` is low, every episode and cycle counter reads 0, the sequence number presented is 0, and both queues are empty.
- R2: Mask bit 0 is the miss queue, bit 1 the write buffer, bit 2 the out-of-targets reason. `stall_o` is high exactly when the registered mask is non-zero, and both update on the clock edge that follows the causing strobe.
- R3: An accepted allocation that brings a queue's occupancy to `DEPTH` sets that queue's mask bit and raises its `*_full_o`.
- R4: An allocation strobe to a full queue is ignored, and a service strobe to an empty queue is ignored. A service strobe clears the queue's mask bit only when the queue was full before it and is not full after it. An allocation and a service in the same cycle on a full queue therefore clears the bit.
- R5: An episode counter (32 bits, counter for reason c at bits [32c+31:32c]) increments only when the mask was empty in that cycle. It increments only for the lowest-coded reason set in that cycle. Setting a reason while the mask is non-zero changes no counter.
- R6: When the mask becomes empty, the number of cycles between the opening strobe and the emptying strobe is added to the 32-bit cycle total of the cleared reason. If several reasons clear together, the lowest-coded one is charged.
- R7: A set and a clear of the same reason in the same cycle act as set-then-clear, with the clear winning. From an empty mask this counts one episode, adds 0 cycles and leaves `stall_o` low.
- R8: The sequence number rises by one per accepted allocation across both queues. `miss_seq_o` shows the number for a miss allocation this cycle. `wb_seq_o` shows that number plus one when a miss allocation is also accepted in the same cycle.
- R9: `miss_line_o` equals `miss_addr_i` with its low log2(`LINE_BYTES`) bits forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_alloc_i | input | 1 | Allocate a miss-queue entry |
| miss_svc_i | input | 1 | Move a miss-queue entry to service |
| miss_addr_i | input | ADDR_W | Request address of the miss allocation |
| wb_alloc_i | input | 1 | Allocate a write-buffer entry |
| wb_svc_i | input | 1 | Move a write-buffer entry to service |
| notgt_set_i | input | 1 | Raise the out-of-targets reason |
| notgt_clr_i | input | 1 | Drop the out-of-targets reason |
| stall_o | output | 1 | Request path stalled |
| cause_mask_o | output | 3 | Per-reason stall mask |
| miss_full_o | output | 1 | Miss queue at DEPTH |
| wb_full_o | output | 1 | Write buffer at DEPTH |
| miss_seq_o | output | SEQ_W | Sequence number for a miss allocation this cycle |
| wb_seq_o | output | SEQ_W | Sequence number for a write-buffer allocation this cycle |
| miss_line_o | output | ADDR_W | Block-aligned miss address |
| episode_cnt_o | output | 96 | Episode counters, 32 bits per reason |
| stall_cyc_o | output | 96 | Stalled-cycle totals, 32 bits per reason |

## Verification
The hardest case to reach from the ports is an episode that closes with two reasons clearing in the same cycle. To get there, the miss queue must be driven exactly to full, and the out-of-targets reason must be stacked on top while the mask is already non-zero. Then one service strobe and the out-of-targets clear are issued together, so the bench can see which total is charged. The stimulus also overlaps the two queues' blocked windows, so that an episode opened by one reason is closed by another. It pairs allocation with service on a full queue, so that an ignored allocation and an effective clear happen in the same cycle.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int NUM_CAUSES = 3;
  localparam int STAT_W     = 32;

  typedef enum logic [1:0] {
    CAUSE_MISSQ = 2'd0,
    CAUSE_WRBUF = 2'd1,
    CAUSE_NOTGT = 2'd2
  } cause_e;

  function automatic int lowest_set(input logic [NUM_CAUSES-1:0] vec);
    int idx;
    idx = 0;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/stall_buf_track.sv
module stall_buf_track #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_i,
  input  logic svc_i,
  output logic accept_o,
  output logic full_o,
  output logic set_o,
  output logic clr_o
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic             drain;

  always_comb begin
    accept_o = alloc_i && (occ_q != FULL_LVL);
    drain    = svc_i && (occ_q != '0);
    occ_d    = occ_q;
    if (accept_o && !drain)      occ_d = occ_q + 1'b1;
    else if (drain && !accept_o) occ_d = occ_q - 1'b1;
    full_o   = (occ_q == FULL_LVL);
    set_o    = accept_o && (occ_d == FULL_LVL);
    clr_o    = full_o && drain && (occ_d != FULL_LVL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL_LVL); // R4

  AST_FULL_HOLDS_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !svc_i) |=> full_o); // R4
endmodule

// File: rtl/stall_cause_mask.sv
module stall_cause_mask
  import stall_pkg::*;
#(
  parameter int NC = NUM_CAUSES,
  parameter int CW = STAT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NC-1:0]  set_i,
  input  logic [NC-1:0]  clr_i,
  output logic [NC-1:0]  mask_o,
  output logic           stall_o,
  output logic [NC*CW-1:0] episode_o,
  output logic [NC*CW-1:0] cycles_o
);
  logic [NC-1:0] mask_q, merged, mask_d;
  logic [CW-1:0] now_q, start_q, start_eff, elapsed;
  logic [CW-1:0] epi_q [NC];
  logic [CW-1:0] cyc_q [NC];
  logic          stall_q, opening, closing;
  int            open_idx, close_idx;

  always_comb begin
    merged    = mask_q | set_i;
    mask_d    = merged & ~clr_i;
    opening   = (mask_q == '0) && (set_i != '0);
    closing   = (merged != '0) && (mask_d == '0);
    open_idx  = lowest_set(set_i);
    close_idx = lowest_set(merged & clr_i);
    start_eff = (mask_q == '0) ? now_q : start_q;
    elapsed   = now_q - start_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      now_q   <= '0;
      start_q <= '0;
      stall_q <= 1'b0;
      for (int c = 0; c < NC; c++) begin
        epi_q[c] <= '0;
        cyc_q[c] <= '0;
      end
    end else begin
      now_q  <= now_q + 1'b1;
      mask_q <= mask_d;
      if (opening) start_q <= now_q;
      if (mask_q == '0 && mask_d != '0) stall_q <= 1'b1;
      else if (mask_d == '0)            stall_q <= 1'b0;
      for (int c = 0; c < NC; c++) begin
        if (opening && open_idx == c)  epi_q[c] <= epi_q[c] + 1'b1;
        if (closing && close_idx == c) cyc_q[c] <= cyc_q[c] + elapsed;
      end
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_flat
    assign episode_o[g*CW +: CW] = epi_q[g];
    assign cycles_o[g*CW +: CW]  = cyc_q[g];
  end

  assign mask_o  = mask_q;
  assign stall_o = stall_q;

  AST_STALL_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o == (mask_q != '0)); // R2

  AST_EPISODE_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (episode_o != $past(episode_o)) |-> ($past(mask_q) == '0)); // R5

  AST_CHARGE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles_o != $past(cycles_o)) |-> (mask_q == '0)); // R6
endmodule

// File: rtl/stall_alloc_seq.sv
module stall_alloc_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SEQ_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_acc_i,
  input  logic              wb_acc_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic [SEQ_W-1:0]  miss_seq_o,
  output logic [SEQ_W-1:0]  wb_seq_o,
  output logic [ADDR_W-1:0] miss_line_o
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [SEQ_W-1:0] seq_q;
  logic [1:0]       n_acc;

  assign n_acc       = {1'b0, miss_acc_i} + {1'b0, wb_acc_i};
  assign miss_seq_o  = seq_q;
  assign wb_seq_o    = seq_q + SEQ_W'(miss_acc_i);
  assign miss_line_o = miss_addr_i & ~OFS_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= '0;
    else        seq_q <= seq_q + SEQ_W'(n_acc);
  end

  initial begin
    AST_LINE_POW2: assert ((1 << OFS_W) == LINE_BYTES); // R9
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (SEQ_W'(seq_q - $past(seq_q)) <= SEQ_W'(2))); // R8
endmodule

// File: rtl/cache_stall_ctrl.sv
module cache_stall_ctrl
  import stall_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SEQ_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         miss_alloc_i,
  input  logic                         miss_svc_i,
  input  logic [ADDR_W-1:0]            miss_addr_i,
  input  logic                         wb_alloc_i,
  input  logic                         wb_svc_i,
  input  logic                         notgt_set_i,
  input  logic                         notgt_clr_i,
  output logic                         stall_o,
  output logic [NUM_CAUSES-1:0]        cause_mask_o,
  output logic                         miss_full_o,
  output logic                         wb_full_o,
  output logic [SEQ_W-1:0]             miss_seq_o,
  output logic [SEQ_W-1:0]             wb_seq_o,
  output logic [ADDR_W-1:0]            miss_line_o,
  output logic [NUM_CAUSES*STAT_W-1:0] episode_cnt_o,
  output logic [NUM_CAUSES*STAT_W-1:0] stall_cyc_o
);
  localparam int NQ = 2;

  logic [NQ-1:0] q_alloc, q_svc, q_acc, q_full, q_set, q_clr;
  logic [NUM_CAUSES-1:0] set_vec, clr_vec;

  assign q_alloc = {wb_alloc_i, miss_alloc_i};
  assign q_svc   = {wb_svc_i, miss_svc_i};

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    stall_buf_track #(.DEPTH(DEPTH)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (q_alloc[q]),
      .svc_i   (q_svc[q]),
      .accept_o(q_acc[q]),
      .full_o  (q_full[q]),
      .set_o   (q_set[q]),
      .clr_o   (q_clr[q])
    );
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[CAUSE_MISSQ] = q_set[0];
    set_vec[CAUSE_WRBUF] = q_set[1];
    set_vec[CAUSE_NOTGT] = notgt_set_i;
    clr_vec[CAUSE_MISSQ] = q_clr[0];
    clr_vec[CAUSE_WRBUF] = q_clr[1];
    clr_vec[CAUSE_NOTGT] = notgt_clr_i;
  end

  stall_cause_mask #(.NC(NUM_CAUSES), .CW(STAT_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .mask_o   (cause_mask_o),
    .stall_o  (stall_o),
    .episode_o(episode_cnt_o),
    .cycles_o (stall_cyc_o)
  );

  stall_alloc_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SEQ_W(SEQ_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_acc_i (q_acc[0]),
    .wb_acc_i   (q_acc[1]),
    .miss_addr_i(miss_addr_i),
    .miss_seq_o (miss_seq_o),
    .wb_seq_o   (wb_seq_o),
    .miss_line_o(miss_line_o)
  );

  assign miss_full_o = q_full[0];
  assign wb_full_o   = q_full[1];

  AST_FULL_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_full_o) |-> cause_mask_o[CAUSE_MISSQ]); // R3

  AST_WB_FULL_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_full_o) |-> cause_mask_o[CAUSE_WRBUF]); // R3
endmodule

// File: tb/cache_stall_ctrl_tb.sv
module cache_stall_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_alloc_i = 0, miss_svc_i = 0, wb_alloc_i = 0, wb_svc_i = 0;
  logic        notgt_set_i = 0, notgt_clr_i = 0;
  logic [31:0] miss_addr_i = '0;
  logic        stall_o, miss_full_o, wb_full_o;
  logic [2:0]  cause_mask_o;
  logic [15:0] miss_seq_o, wb_seq_o;
  logic [31:0] miss_line_o;
  logic [95:0] episode_cnt_o, stall_cyc_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cache_stall_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_alloc_i(miss_alloc_i), .miss_svc_i(miss_svc_i), .miss_addr_i(miss_addr_i),
    .wb_alloc_i(wb_alloc_i), .wb_svc_i(wb_svc_i),
    .notgt_set_i(notgt_set_i), .notgt_clr_i(notgt_clr_i),
    .stall_o(stall_o), .cause_mask_o(cause_mask_o),
    .miss_full_o(miss_full_o), .wb_full_o(wb_full_o),
    .miss_seq_o(miss_seq_o), .wb_seq_o(wb_seq_o), .miss_line_o(miss_line_o),
    .episode_cnt_o(episode_cnt_o), .stall_cyc_o(stall_cyc_o)
  );

  // {ma, ms, wa, ws, ns, nc, mask[2:0], mfull, wfull}
  localparam int NV = 25;
  localparam logic [10:0] VEC [NV] = '{
    11'b100000_000_00, 11'b100000_000_00, 11'b100000_000_00,
    11'b100000_001_10, 11'b100000_001_10,
    11'b001000_001_10, 11'b001000_001_10, 11'b001000_001_10, 11'b001000_011_11,
    11'b010000_010_01, 11'b010000_010_01,
    11'b000010_110_01, 11'b000100_100_00, 11'b000001_000_00,
    11'b100000_000_00, 11'b100000_001_10, 11'b110000_000_00,
    11'b010000_000_00, 11'b010000_000_00, 11'b010000_000_00, 11'b010000_000_00,
    11'b000100_000_00, 11'b000100_000_00, 11'b000100_000_00, 11'b000100_000_00
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ma, ms, wa, ws, ns, nc);
    miss_alloc_i = ma; miss_svc_i = ms; wb_alloc_i = wa;
    wb_svc_i = ws; notgt_set_i = ns; notgt_clr_i = nc;
  endtask

  task automatic step(input logic ma, ms, wa, ws, ns, nc);
    drive(ma, ms, wa, ws, ns, nc);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [31:0] f32(input logic [95:0] v, input int c);
    return v[c*32 +: 32];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 mask", 32'(cause_mask_o), 0);
    chk("R1 stall", 32'(stall_o), 0);
    chk("R1 episodes", 32'(|episode_cnt_o), 0);
    chk("R1 cycles", 32'(|stall_cyc_o), 0);
    chk("R1 seq", 32'(miss_seq_o), 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk($sformatf("R2 R3 R4 row %0d mask", i), 32'(cause_mask_o), 32'(VEC[i][4:2]));
      chk($sformatf("R2 row %0d stall", i), 32'(stall_o), 32'(|VEC[i][4:2]));
      chk($sformatf("R3 row %0d mfull", i), 32'(miss_full_o), 32'(VEC[i][1]));
      chk($sformatf("R4 row %0d wfull", i), 32'(wb_full_o), 32'(VEC[i][0]));
    end
    // R5 R6 statistics after table
    chk("R5 episodes missq", f32(episode_cnt_o, 0), 2);
    chk("R5 episodes wrbuf", f32(episode_cnt_o, 1), 0);
    chk("R5 episodes notgt", f32(episode_cnt_o, 2), 0);
    chk("R6 cycles missq", f32(stall_cyc_o, 0), 1);
    chk("R6 cycles wrbuf", f32(stall_cyc_o, 1), 0);
    chk("R6 cycles notgt", f32(stall_cyc_o, 2), 10);

    // R7 set and clear together from empty
    step(0, 0, 0, 0, 1, 1);
    chk("R7 mask", 32'(cause_mask_o), 0);
    chk("R7 stall", 32'(stall_o), 0);
    chk("R7 episode", f32(episode_cnt_o, 2), 1);
    chk("R7 cycles", f32(stall_cyc_o, 2), 10);

    // R6 two reasons clear together: lowest code charged
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0);
    chk("R3 full again", 32'(cause_mask_o), 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R5 no episode while stalled", f32(episode_cnt_o, 2), 1);
    chk("R5 mask stacked", 32'(cause_mask_o), 3'b101);
    step(0, 1, 0, 0, 0, 1);
    chk("R6 mask empty", 32'(cause_mask_o), 0);
    chk("R6 charged missq", f32(stall_cyc_o, 0), 3);
    chk("R6 notgt untouched", f32(stall_cyc_o, 2), 10);
    chk("R5 episodes missq", f32(episode_cnt_o, 0), 3);

    // R8 sequence numbers, R9 line address
    drive(1, 0, 1, 0, 0, 0);
    miss_addr_i = 32'h1234_5678;
    #1;
    chk("R8 miss seq", 32'(miss_seq_o), 14);
    chk("R8 wb seq", 32'(wb_seq_o), 15);
    chk("R9 line", miss_line_o, 32'h1234_5640);
    @(negedge clk);
    drive(1, 0, 0, 0, 0, 0);
    miss_addr_i = 32'hFFFF_FFFF;
    #1;
    chk("R8 miss seq after", 32'(miss_seq_o), 16);
    chk("R8 wb seq ignored alloc", 32'(wb_seq_o), 16);
    chk("R9 line high", miss_line_o, 32'hFFFF_FFC0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    #1;
    chk("R4 full alloc ignored seq", 32'(miss_seq_o), 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule